// File: doc/BRIEF.md
# Torus Minimal Adaptive Route Selector

This block makes the next-hop decision for one packet header at a router in a three-dimensional torus. Each node has six neighbour links, a plus link and a minus link in each of X, Y and Z. The block takes the local coordinate, the destination coordinate and the ring length of each dimension. From these it works out which links move the packet strictly closer to its destination, with wraparound taken into account. It then picks one of those links that the output arbiters report as ready. It also decides whether the local node keeps a copy of the packet.

Routing is minimal and normally adaptive: any productive link in any unfinished dimension may be taken, and a fixed priority breaks ties. A dimension-order control input restricts the choice to the lowest unfinished dimension, which gives a deadlock-free escape path. A deposit flag marks a multicast along a straight line. Such a packet is copied to every node it passes through. It must therefore differ from the local node in at most one dimension, and a violation is flagged.

Headers are accepted with a valid/ready handshake. The decision is registered and appears one cycle after acceptance. It stays frozen until the consumer acknowledges it.

Top module: `torus_route_sel`

## Requirements
- R1: In each dimension the remaining distance is delta = (dst - cur) mod ring. A dimension with delta = 0 is finished. Otherwise plus is productive when 2*delta <= ring, so an exact half-ring tie goes to plus, and minus is productive when 2*delta > ring. Link bit positions are 0 X+, 1 X-, 2 Y+, 3 Y-, 4 Z+, 5 Z-.
- R2: With dimension-order mode off, the candidate mask `cand_link` holds the productive link of every unfinished dimension.
- R3: The selected link is the lowest-numbered bit of `cand_link & link_ready`. `sel_link` is one-hot or zero.
- R4: When the packet has not arrived, has no deposit error, and no candidate link is ready, `stall` is 1 and `sel_link` is 0.
- R5: With dimension-order mode on, `cand_link` holds only the productive link of the lowest unfinished dimension (X before Y before Z).
- R6: When all three dimensions are finished, `local_dlv` is 1 and `sel_link`, `cand_link`, `fwd` and `stall` are 0.
- R7: A deposit packet with exactly one unfinished dimension that is forwarded also raises `local_dlv`. If it stalls, `local_dlv` stays 0.
- R8: A deposit packet with more than one unfinished dimension raises `err`. It forces `sel_link`, `local_dlv`, `fwd` and `stall` to 0, while `cand_link` is still reported.
- R9: `in_ready` equals `!out_valid || out_ack`. A header is taken when `in_valid && in_ready`, and its decision appears with `out_valid` = 1 after the next clock edge. An acknowledge with no new header clears `out_valid`. While `out_valid` is 1 and `out_ack` is 0, every decision output holds its value.
- R10: Synchronous active-high reset clears `out_valid` and every decision output, leaving `in_ready` at 1.
- R11: `fwd` is 1 exactly when the decision selects a link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header can be taken this cycle |
| cur_x | input | XW | Local X coordinate |
| cur_y | input | YW | Local Y coordinate |
| cur_z | input | ZW | Local Z coordinate |
| dst_x | input | XW | Destination X coordinate |
| dst_y | input | YW | Destination Y coordinate |
| dst_z | input | ZW | Destination Z coordinate |
| ring_x | input | XW+1 | Ring length in X (1..2^XW) |
| ring_y | input | YW+1 | Ring length in Y (1..2^YW) |
| ring_z | input | ZW+1 | Ring length in Z (1..2^ZW) |
| deposit | input | 1 | Copy to every node along a line |
| dim_order | input | 1 | Restrict to lowest unfinished dimension |
| link_ready | input | 6 | Per-link arbiter ready, bit order as R1 |
| out_valid | output | 1 | Decision presented |
| out_ack | input | 1 | Decision consumed |
| sel_link | output | 6 | One-hot chosen link or zero |
| cand_link | output | 6 | Allowed productive links |
| local_dlv | output | 1 | Deliver to local node |
| fwd | output | 1 | Packet continues on a link |
| stall | output | 1 | No allowed link ready |
| err | output | 1 | Deposit packet off a single line |

## Verification
Directed headers cover the exact half-ring tie, a short wraparound path against a long direct path, odd ring lengths, rings of length one, and the largest rings. Together they separate a correct modular distance from one that ignores wraparound or breaks ties toward minus. A single header is presented with dimension-order mode off and then on, under a ready mask that admits only a higher dimension. This separates adaptive choice from the escape mode. Deposit headers that differ in one dimension, that differ in two, and that stall distinguish line delivery from the error case. Long random runs with random ready masks, random acknowledges and back-to-back headers check the handshake, the hold behaviour and the priority order cycle by cycle.

// File: rtl/torus_route_pkg.sv
package torus_route_pkg;
  localparam int NDIM  = 3;
  localparam int NLINK = 2 * NDIM;

  typedef struct packed {
    logic [NLINK-1:0] sel;
    logic [NLINK-1:0] cand;
    logic             deliver;
    logic             fwd;
    logic             stall;
    logic             err;
  } route_dec_t;
endpackage

// File: rtl/torus_dim_dir.sv
// Per-dimension minimal direction with wraparound.
module torus_dim_dir #(
  parameter int W = 5
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] dst,
  input  logic [W:0]   ring,
  output logic         done,
  output logic         go_plus,
  output logic         go_minus
);
  localparam int DW = W + 1;

  logic [DW-1:0] c_ext, d_ext, delta, half;

  assign c_ext = {1'b0, cur};
  assign d_ext = {1'b0, dst};
  assign half  = ring >> 1;

  always_comb begin
    if (d_ext >= c_ext) delta = d_ext - c_ext;
    else                delta = d_ext + ring - c_ext;
  end

  // tie at exactly half the ring resolves to plus
  assign done     = (delta == '0);
  assign go_plus  = !done && (delta <= half);
  assign go_minus = !done && (delta >  half);
endmodule

// File: rtl/torus_route_core.sv
// Combinational decision: candidate masking, priority pick, delivery rules.
module torus_route_core
  import torus_route_pkg::*;
(
  input  logic [NDIM-1:0]  done,
  input  logic [NDIM-1:0]  plus,
  input  logic [NDIM-1:0]  minus,
  input  logic             deposit,
  input  logic             dim_order,
  input  logic [NLINK-1:0] link_ready,
  output route_dec_t       dec
);
  logic [NLINK-1:0] all_cand, dor_cand, cand, avail, grant;
  logic [NDIM-1:0]  first_open;
  logic             arrived, multi;
  int unsigned      open_cnt;

  for (genvar g = 0; g < NDIM; g++) begin : g_dim
    assign all_cand[2*g]   = plus[g];
    assign all_cand[2*g+1] = minus[g];
    if (g == 0) begin : g_first
      assign first_open[g] = !done[g];
    end else begin : g_rest
      assign first_open[g] = !done[g] && (&done[g-1:0]);
    end
    assign dor_cand[2*g+1:2*g] = all_cand[2*g+1:2*g] & {2{first_open[g]}};
  end

  always_comb begin
    open_cnt = 0;
    for (int i = 0; i < NDIM; i++) open_cnt += {31'd0, !done[i]};
  end

  assign arrived = &done;
  assign multi   = open_cnt > 1;
  assign cand    = dim_order ? dor_cand : all_cand;
  assign avail   = cand & link_ready;
  assign grant   = avail & (~avail + 1'b1);  // lowest set bit wins

  always_comb begin
    dec = '0;
    if (arrived) begin
      dec.deliver = 1'b1;
    end else if (deposit && multi) begin
      dec.err  = 1'b1;
      dec.cand = cand;
    end else begin
      dec.cand    = cand;
      dec.sel     = grant;
      dec.fwd     = |grant;
      dec.stall   = ~|grant;
      dec.deliver = deposit && (|grant);
    end
  end
endmodule

// File: rtl/torus_route_sel.sv
module torus_route_sel
  import torus_route_pkg::*;
#(
  parameter int XW = 5,
  parameter int YW = 5,
  parameter int ZW = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XW-1:0]    cur_x,
  input  logic [YW-1:0]    cur_y,
  input  logic [ZW-1:0]    cur_z,
  input  logic [XW-1:0]    dst_x,
  input  logic [YW-1:0]    dst_y,
  input  logic [ZW-1:0]    dst_z,
  input  logic [XW:0]      ring_x,
  input  logic [YW:0]      ring_y,
  input  logic [ZW:0]      ring_z,
  input  logic             deposit,
  input  logic             dim_order,
  input  logic [NLINK-1:0] link_ready,
  output logic             out_valid,
  input  logic             out_ack,
  output logic [NLINK-1:0] sel_link,
  output logic [NLINK-1:0] cand_link,
  output logic             local_dlv,
  output logic             fwd,
  output logic             stall,
  output logic             err
);
  logic [NDIM-1:0] done, plus, minus;
  route_dec_t      dec_c, dec_q;
  logic            valid_q, accept;

  torus_dim_dir #(.W(XW)) u_dx (.cur(cur_x), .dst(dst_x), .ring(ring_x),
    .done(done[0]), .go_plus(plus[0]), .go_minus(minus[0]));
  torus_dim_dir #(.W(YW)) u_dy (.cur(cur_y), .dst(dst_y), .ring(ring_y),
    .done(done[1]), .go_plus(plus[1]), .go_minus(minus[1]));
  torus_dim_dir #(.W(ZW)) u_dz (.cur(cur_z), .dst(dst_z), .ring(ring_z),
    .done(done[2]), .go_plus(plus[2]), .go_minus(minus[2]));

  torus_route_core u_core (
    .done(done), .plus(plus), .minus(minus), .deposit(deposit),
    .dim_order(dim_order), .link_ready(link_ready), .dec(dec_c)
  );

  assign in_ready = !valid_q || out_ack;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      dec_q   <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      dec_q   <= dec_c;
    end else if (out_ack) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign sel_link  = dec_q.sel;
  assign cand_link = dec_q.cand;
  assign local_dlv = dec_q.deliver;
  assign fwd       = dec_q.fwd;
  assign stall     = dec_q.stall;
  assign err       = dec_q.err;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(sel_link)); // R3
  AST_SEL_IN_CAND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((sel_link & ~cand_link) == '0)); // R3
  AST_STALL_NO_LINK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && stall) |-> (sel_link == '0 && !fwd && !local_dlv)); // R4
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (out_valid && err) |-> (sel_link == '0 && !local_dlv && !stall)); // R8
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ack) |=> (out_valid && $stable(sel_link) && $stable(cand_link)
                                 && $stable(local_dlv) && $stable(err))); // R9
  AST_FWD_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (fwd == (sel_link != '0))); // R11
  AST_ARRIVE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && local_dlv && !fwd) |-> (cand_link == '0 && !stall)); // R6
endmodule

// File: tb/tb_torus_route_sel.sv
module tb_torus_route_sel;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_ready, out_valid, out_ack = 0;
  logic [4:0] cur_x = 0, cur_y = 0, dst_x = 0, dst_y = 0;
  logic [5:0] cur_z = 0, dst_z = 0;
  logic [5:0] ring_x = 1, ring_y = 1;
  logic [6:0] ring_z = 1;
  logic deposit = 0, dim_order = 0;
  logic [5:0] link_ready = 0, sel_link, cand_link;
  logic local_dlv, fwd, stall, err;

  int checks = 0, fails = 0;
  logic        exp_valid = 0;
  logic [15:0] exp_dec = '0;

  always #4 clk = ~clk;

  torus_route_sel dut (.*);

  // packed as {sel[15:10], cand[9:4], deliver, fwd, stall, err}
  function automatic logic [15:0] model(int cx, int cy, int cz, int dx, int dy, int dz,
      int sx, int sy, int sz, bit dep, bit dor, logic [5:0] rdy);
    int c[3], d[3], s[3];
    int open_n = 0, first = -1, delta;
    logic [5:0] allc = 0, cnd = 0, sel = 0;
    c[0]=cx; c[1]=cy; c[2]=cz; d[0]=dx; d[1]=dy; d[2]=dz; s[0]=sx; s[1]=sy; s[2]=sz;
    for (int k = 0; k < 3; k++) begin
      delta = ((d[k] - c[k]) % s[k] + s[k]) % s[k];
      if (delta != 0) begin
        open_n++;
        if (first < 0) first = k;
        if (2 * delta <= s[k]) allc[2*k] = 1; else allc[2*k+1] = 1;
      end
    end
    if (open_n == 0) return 16'b0000000000_1000;
    cnd = allc;
    if (dor) begin
      cnd = 0;
      cnd[2*first] = allc[2*first];
      cnd[2*first+1] = allc[2*first+1];
    end
    if (dep && open_n > 1) return {6'd0, cnd, 4'b0001};
    for (int i = 0; i < 6; i++)
      if (sel == 0 && cnd[i] && rdy[i]) sel[i] = 1;
    return {sel, cnd, dep && (sel != 0), sel != 0, sel == 0, 1'b0};
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // reference model advances on every edge
  always @(posedge clk) begin
    if (rst) begin
      exp_valid = 0; exp_dec = '0;
    end else if (in_valid && (!exp_valid || out_ack)) begin
      exp_valid = 1;
      exp_dec = model(cur_x, cur_y, cur_z, dst_x, dst_y, dst_z, ring_x, ring_y, ring_z,
                      deposit, dim_order, link_ready);
    end else if (out_ack) exp_valid = 0;
  end

  // compared every cycle, away from the active edge
  always @(negedge clk) if (!rst) begin
    chk("R9 out_valid", out_valid, exp_valid);
    chk("R9 in_ready", in_ready, !exp_valid || out_ack);
    chk("R3 sel_link", sel_link, exp_dec[15:10]);
    chk("R1 cand_link", cand_link, exp_dec[9:4]);
    chk("R6 local_dlv", local_dlv, exp_dec[3]);
    chk("R11 fwd", fwd, exp_dec[2]);
    chk("R4 stall", stall, exp_dec[1]);
    chk("R8 err", err, exp_dec[0]);
  end

  task automatic send(int cx, int cy, int cz, int dx, int dy, int dz,
                      int sx, int sy, int sz, bit dep, bit dor, logic [5:0] rdy);
    @(posedge clk); #2;
    cur_x = cx; cur_y = cy; cur_z = cz; dst_x = dx; dst_y = dy; dst_z = dz;
    ring_x = sx; ring_y = sy; ring_z = sz; deposit = dep; dim_order = dor;
    link_ready = rdy; in_valid = 1; out_ack = 1;
    @(posedge clk); #2;
    in_valid = 0; out_ack = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    chk("R10 out_valid", out_valid, 0);
    chk("R10 in_ready", in_ready, 1);
    chk("R10 sel_link", sel_link, 0);
    chk("R10 flags", {local_dlv, fwd, stall, err}, 0);

    // R1 half-ring tie goes plus
    send(0,3,3, 4,3,3, 8,8,8, 0,0, 6'h3F);
    chk("R1 tie plus", sel_link, 6'b000001);
    // R1 wraparound shorter path
    send(1,0,0, 7,0,0, 8,8,8, 0,0, 6'h3F);
    chk("R1 wrap minus", sel_link, 6'b000010);
    // R1 largest rings, z delta 33 of 64 -> minus
    send(0,0,0, 0,16,33, 32,32,64, 0,0, 6'h3F);
    chk("R1 max rings cand", cand_link, 6'b100100);
    // R2 adaptive: only Y- ready
    send(2,0,0, 3,4,0, 8,5,4, 0,0, 6'b001000);
    chk("R2 adaptive cand", cand_link, 6'b001001);
    chk("R2 adaptive sel", sel_link, 6'b001000);
    // R5 same header in dimension order stalls
    send(2,0,0, 3,4,0, 8,5,4, 0,1, 6'b001000);
    chk("R5 dor cand", cand_link, 6'b000001);
    chk("R5 dor stall", stall, 1);
    // R4 nothing ready
    send(0,0,0, 1,1,1, 4,4,4, 0,0, 6'b000000);
    chk("R4 stall", {stall, sel_link}, 7'b1000000);
    // R6 arrival
    send(5,6,7, 5,6,7, 8,8,8, 0,0, 6'h3F);
    chk("R6 arrive", {local_dlv, fwd, sel_link}, 8'b10000000);
    // R7 deposit along Z
    send(1,1,1, 1,1,3, 4,4,8, 1,0, 6'h3F);
    chk("R7 deposit fwd", {local_dlv, fwd, sel_link}, 8'b11010000);
    send(1,1,1, 1,1,3, 4,4,8, 1,0, 6'h00);
    chk("R7 deposit stall", {local_dlv, stall}, 2'b01);
    // R8 deposit off line
    send(0,0,0, 1,1,0, 4,4,4, 1,0, 6'h3F);
    chk("R8 err", {err, sel_link, local_dlv}, 8'b10000000);
    // R9 hold without ack
    repeat (3) @(negedge clk);
    chk("R9 held", {out_valid, err}, 2'b11);

    // random traffic, back-to-back and random acknowledges
    for (int n = 0; n < 4000; n++) begin
      int sx, sy, sz, sparse;
      @(posedge clk); #2;
      sx = 1 + $urandom % 32; sy = 1 + $urandom % 32; sz = 1 + $urandom % 64;
      ring_x = sx; ring_y = sy; ring_z = sz;
      cur_x = $urandom % sx; cur_y = $urandom % sy; cur_z = $urandom % sz;
      dst_x = $urandom % sx; dst_y = $urandom % sy; dst_z = $urandom % sz;
      sparse = $urandom % 4;
      if (sparse == 1) begin dst_y = cur_y; dst_z = cur_z; end
      if (sparse == 2) begin dst_x = cur_x; dst_z = cur_z; end
      if (sparse == 3) begin dst_x = cur_x; dst_y = cur_y; end
      deposit = $urandom % 2; dim_order = $urandom % 2;
      link_ready = $urandom; in_valid = $urandom % 2; out_ack = $urandom % 2;
    end
    @(posedge clk); #2 in_valid = 0; out_ack = 1;
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule